// File: doc/BRIEF.md
# Low-Quadword Vector Move Unit

This unit executes one instruction that transfers the low 64-bit lane between memory and a vector register. Operand fetch is done elsewhere. Each cycle the unit takes already-decoded fields, the 64-bit value read from memory and the register operands it may need. One clock later it presents one of three results: a register write (enable and a full-width value), a 64-bit store request, or an invalid-opcode fault.

There are three encoding forms. The legacy form puts the memory value into the low lane and keeps every other destination bit. The two prefixed forms build the low 128 bits from the memory value and the upper quadword of a separate first source, and they clear everything above bit 127. The store direction copies the low quadword of a register out to memory. Data moves bit for bit; NaN patterns and denormals pass unchanged.

The unit has no back-pressure. A result appears on the outputs for exactly one cycle, and the consumer must take it in that cycle. The `in_valid` strobe may be high on any number of consecutive cycles.

Top module: `lqm_unit`

## Requirements
- R1: `in_opcode` 0x12 selects a load (memory to register) and 0x13 selects a store (register to memory). `in_form` encodes 0 = legacy, 1 = short prefix, 2 = long prefix and 3 = reserved. A reserved form or any other opcode produces no write, no store and no fault.
- R2: A legal legacy load writes `mem_rdata` into bits 63:0 and takes bits MAXVL-1:64 unchanged from `src_a`, the current destination contents. This holds for MAXVL = 128, 256 and 512.
- R3: A legal prefixed load writes `mem_rdata` into bits 63:0 and `src_b_hi` into bits 127:64, and forces bits MAXVL-1:128 to zero.
- R4: A legal store raises `st_en` with `st_data` equal to `src_a[63:0]`, and leaves `wr_en` low.
- R5: `in_mod` = 2'b11 (register operand) raises `fault_ud` in every form and in both directions.
- R6: A prefixed store with `in_vspec` other than 4'b1111 raises `fault_ud`. Legacy forms and prefixed loads ignore `in_vspec`.
- R7: A prefixed form with a nonzero `in_vlen` raises `fault_ud`. The legacy form ignores `in_vlen`.
- R8: Whenever `fault_ud` is high, `wr_en` and `st_en` are low. At most one of `wr_en`, `st_en` and `fault_ud` is high in any cycle.
- R9: Every output is registered and reflects the inputs of the previous cycle. After a cycle with `in_valid` low, all outputs, data included, are zero. Reset clears all outputs.
- R10: Data is copied bit-exactly, including NaN and all-ones patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_form | input | 2 | Encoding form: 0 legacy, 1 short prefix, 2 long prefix, 3 reserved |
| in_opcode | input | 8 | Opcode byte, 0x12 load or 0x13 store |
| in_mod | input | 2 | ModRM mod field |
| in_vlen | input | 2 | Prefix vector-length field |
| in_vspec | input | 4 | Prefix register-specifier field |
| mem_rdata | input | 64 | Value read from memory |
| src_a | input | MAXVL | Current destination (load) or store source register |
| src_b_hi | input | 64 | Bits 127:64 of the first source of a prefixed load |
| wr_en | output | 1 | Register write enable |
| wr_data | output | MAXVL | Register write value |
| st_en | output | 1 | Store request |
| st_data | output | 64 | Store value |
| fault_ud | output | 1 | Invalid-opcode fault |

## Verification
Directed cases drive each form in both directions with distinct patterns in the low lane, in bits 127:64 and above bit 127. These patterns separate keeping the upper bits (legacy) from merging them and zeroing them (prefixed). Further directed cases each break exactly one legality rule: register mod, a nonzero length field, or a wrong specifier on a prefixed store. Each must fault. A copy with a legal field that a correct unit ignores must still execute. Random stimulus mixes legal and illegal fields, reserved forms and stray opcodes, with idle gaps. NaN and all-ones words confirm that values pass through untouched.

// File: rtl/lqm_pkg.sv
package lqm_pkg;
  typedef enum logic [1:0] {
    FORM_LEGACY    = 2'd0,
    FORM_PFX_SHORT = 2'd1,
    FORM_PFX_LONG  = 2'd2,
    FORM_RSVD      = 2'd3
  } form_e;

  localparam logic [7:0] OPC_LOAD  = 8'h12;
  localparam logic [7:0] OPC_STORE = 8'h13;
  localparam logic [1:0] MOD_REG   = 2'b11;
  localparam logic [3:0] VSPEC_NONE = 4'b1111;
  localparam int QW   = 64;
  localparam int LANE = 128;

  typedef struct packed {
    logic load;
    logic store;
    logic fault;
    logic pfx;
  } action_t;
endpackage

// File: rtl/lqm_decode.sv
module lqm_decode
  import lqm_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] form,
  input  logic [7:0] opcode,
  input  logic [1:0] mod_f,
  input  logic [1:0] vlen,
  input  logic [3:0] vspec,
  output action_t    act
);
  form_e f;
  logic  is_pfx, is_ld, is_st, known, bad;

  always_comb begin
    f      = form_e'(form);
    is_pfx = (f == FORM_PFX_SHORT) || (f == FORM_PFX_LONG);
    is_ld  = (opcode == OPC_LOAD);
    is_st  = (opcode == OPC_STORE);
    known  = valid && (f != FORM_RSVD) && (is_ld || is_st);
    bad    = (mod_f == MOD_REG)
          || (is_pfx && (vlen != 2'b00))
          || (is_pfx && is_st && (vspec != VSPEC_NONE));
    act.fault = known && bad;
    act.load  = known && !bad && is_ld;
    act.store = known && !bad && is_st;
    act.pfx   = is_pfx;
  end
endmodule

// File: rtl/lqm_merge.sv
module lqm_merge
  import lqm_pkg::*;
#(
  parameter int MAXVL = 256
) (
  input  logic             pfx,
  input  logic [QW-1:0]    mem_rdata,
  input  logic [MAXVL-1:0] src_a,
  input  logic [QW-1:0]    src_b_hi,
  output logic [MAXVL-1:0] merged
);
  localparam int UPPER = MAXVL - LANE;

  always_comb begin
    merged[QW-1:0]   = mem_rdata;
    merged[LANE-1:QW] = pfx ? src_b_hi : src_a[LANE-1:QW];
  end

  generate
    if (UPPER > 0) begin : g_upper
      always_comb merged[MAXVL-1:LANE] = pfx ? '0 : src_a[MAXVL-1:LANE];
    end
    if (MAXVL != 128 && MAXVL != 256 && MAXVL != 512) begin : g_bad_width
      $error("lqm_merge: MAXVL must be 128, 256 or 512");
    end
  endgenerate
endmodule

// File: rtl/lqm_unit.sv
module lqm_unit
  import lqm_pkg::*;
#(
  parameter int MAXVL = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_form,
  input  logic [7:0]       in_opcode,
  input  logic [1:0]       in_mod,
  input  logic [1:0]       in_vlen,
  input  logic [3:0]       in_vspec,
  input  logic [63:0]      mem_rdata,
  input  logic [MAXVL-1:0] src_a,
  input  logic [63:0]      src_b_hi,
  output logic             wr_en,
  output logic [MAXVL-1:0] wr_data,
  output logic             st_en,
  output logic [63:0]      st_data,
  output logic             fault_ud
);
  action_t          act;
  logic [MAXVL-1:0] merged;

  lqm_decode u_dec (
    .valid (in_valid), .form (in_form), .opcode (in_opcode),
    .mod_f (in_mod), .vlen (in_vlen), .vspec (in_vspec), .act (act)
  );

  lqm_merge #(.MAXVL(MAXVL)) u_mrg (
    .pfx (act.pfx), .mem_rdata (mem_rdata), .src_a (src_a),
    .src_b_hi (src_b_hi), .merged (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en    <= 1'b0;
      wr_data  <= '0;
      st_en    <= 1'b0;
      st_data  <= '0;
      fault_ud <= 1'b0;
    end else begin
      wr_en    <= act.load;
      wr_data  <= act.load ? merged : '0;
      st_en    <= act.store;
      st_data  <= act.store ? src_a[QW-1:0] : '0;
      fault_ud <= act.fault;
    end
  end

  // R8: outcomes are mutually exclusive
  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, st_en, fault_ud}));

  // R9: idle cycle gives quiet outputs
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> (!wr_en && !st_en && !fault_ud && wr_data == '0 && st_data == '0));

  // R4: store carries the low quadword of src_a
  a_r4_store_data: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |-> (st_data == $past(src_a[QW-1:0]) && $past(in_opcode) == OPC_STORE));

  // R2/R3: low lane always comes from memory
  a_r2_low_lane: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data[QW-1:0] == $past(mem_rdata)));

  // R2: legacy keeps everything above the low lane
  a_r2_legacy_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(in_form) == 2'd0) |-> (wr_data[MAXVL-1:QW] == $past(src_a[MAXVL-1:QW])));

  // R5: register mod never executes
  a_r5_mod_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || st_en) |-> ($past(in_mod) != MOD_REG));

  generate
    if (MAXVL > LANE) begin : g_chk_upper
      // R3: prefixed load clears above bit 127
      a_r3_pfx_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(in_form) != 2'd0) |-> (wr_data[MAXVL-1:LANE] == '0));
    end
  endgenerate
endmodule

// File: tb/sim_lqm_unit.sv
module sim_lqm_unit;
  localparam int MV = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_form = '0, in_mod = '0, in_vlen = '0;
  logic [7:0] in_opcode = '0;
  logic [3:0] in_vspec = '0;
  logic [63:0] mem_rdata = '0, src_b_hi = '0;
  logic [MV-1:0] src_a = '0;
  logic wr_en, st_en, fault_ud;
  logic [MV-1:0] wr_data;
  logic [63:0] st_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lqm_unit #(.MAXVL(MV)) u0 (
    .clk, .rst_n, .in_valid, .in_form, .in_opcode, .in_mod, .in_vlen,
    .in_vspec, .mem_rdata, .src_a, .src_b_hi, .wr_en, .wr_data, .st_en,
    .st_data, .fault_ud
  );

  typedef struct packed {
    logic w; logic s; logic f;
    logic [MV-1:0] wd; logic [63:0] sd;
  } exp_t;

  function automatic exp_t model(logic v, logic [1:0] fm, logic [7:0] op,
      logic [1:0] md, logic [1:0] vl, logic [3:0] vs,
      logic [63:0] m, logic [MV-1:0] a, logic [63:0] bh);
    exp_t e = '0;
    bit pf = (fm == 2'd1) || (fm == 2'd2);
    bit ok = v && fm != 2'd3 && (op == 8'h12 || op == 8'h13);
    bit ill;
    if (!ok) return e;
    ill = (md == 2'b11) || (pf && vl != 0) || (pf && op == 8'h13 && vs != 4'hF);
    if (ill) begin e.f = 1; return e; end
    if (op == 8'h13) begin e.s = 1; e.sd = a[63:0]; return e; end
    e.w = 1;
    if (pf) e.wd = {{(MV-128){1'b0}}, bh, m};
    else    e.wd = {a[MV-1:64], m};
    return e;
  endfunction

  function automatic logic [MV-1:0] rnd_vec();
    logic [MV-1:0] r;
    for (int i = 0; i < MV/32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic check(string tag, exp_t e);
    checks++;
    if (wr_en !== e.w || st_en !== e.s || fault_ud !== e.f ||
        wr_data !== e.wd || st_data !== e.sd) begin
      errors++;
      $display("FAIL %s: got w=%0b s=%0b f=%0b wd=%h sd=%h exp w=%0b s=%0b f=%0b wd=%h sd=%h",
        tag, wr_en, st_en, fault_ud, wr_data, st_data, e.w, e.s, e.f, e.wd, e.sd);
    end
  endtask

  task automatic run(string tag, logic v, logic [1:0] fm, logic [7:0] op,
      logic [1:0] md, logic [1:0] vl, logic [3:0] vs,
      logic [63:0] m, logic [MV-1:0] a, logic [63:0] bh);
    exp_t e = model(v, fm, op, md, vl, vs, m, a, bh);
    in_valid = v; in_form = fm; in_opcode = op; in_mod = md;
    in_vlen = vl; in_vspec = vs; mem_rdata = m; src_a = a; src_b_hi = bh;
    @(negedge clk);
    check(tag, e);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [MV-1:0] a;
    logic [63:0] m, b;
    void'($urandom(32'd2024));
    a = {64'hAAAA_0000_AAAA_0001, 64'hBBBB_0000_BBBB_0002, 64'hCCCC_1111_2222_3333, 64'h4444_5555_6666_7777};
    m = 64'h7FF8_0000_0000_0001;   // NaN pattern, R10
    b = 64'hDEAD_BEEF_0BAD_F00D;
    repeat (2) @(negedge clk);
    check("R9 reset", '0);
    rst_n = 1'b1;
    @(negedge clk);
    run("R2 legacy load",        1, 2'd0, 8'h12, 2'b00, 2'd0, 4'h0, m, a, b);
    run("R7 legacy ignores vlen", 1, 2'd0, 8'h12, 2'b01, 2'd3, 4'h5, m, a, b);
    run("R3 short prefix load",  1, 2'd1, 8'h12, 2'b10, 2'd0, 4'h3, m, a, b);
    run("R6 pfx load ignores vspec", 1, 2'd2, 8'h12, 2'b00, 2'd0, 4'h0, m, a, b);
    run("R4 legacy store",       1, 2'd0, 8'h13, 2'b00, 2'd0, 4'h2, m, a, b);
    run("R4 prefixed store",     1, 2'd2, 8'h13, 2'b01, 2'd0, 4'hF, m, a, b);
    run("R5 mod reg legacy",     1, 2'd0, 8'h12, 2'b11, 2'd0, 4'hF, m, a, b);
    run("R5 mod reg pfx store",  1, 2'd1, 8'h13, 2'b11, 2'd0, 4'hF, m, a, b);
    run("R6 pfx store vspec",    1, 2'd1, 8'h13, 2'b00, 2'd0, 4'hE, m, a, b);
    run("R7 pfx vlen",           1, 2'd2, 8'h12, 2'b00, 2'd1, 4'hF, m, a, b);
    run("R1 reserved form",      1, 2'd3, 8'h12, 2'b00, 2'd0, 4'hF, m, a, b);
    run("R1 other opcode",       1, 2'd0, 8'h14, 2'b00, 2'd0, 4'hF, m, a, b);
    run("R9 idle",               0, 2'd0, 8'h12, 2'b00, 2'd0, 4'hF, m, a, b);
    run("R10 all ones",          1, 2'd0, 8'h12, 2'b00, 2'd0, 4'hF, '1, '1, '1);
    run("R3 zero upper all ones", 1, 2'd1, 8'h12, 2'b00, 2'd0, 4'hF, '1, '1, '1);
    for (int i = 0; i < 400; i++) begin
      logic [7:0] op;
      int sel = $urandom_range(0, 9);
      op = (sel < 5) ? 8'h12 : (sel < 9) ? 8'h13 : 8'($urandom);
      run("R8 random mix", ($urandom_range(0, 5) != 0),
          2'($urandom), op, 2'($urandom),
          ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'd0,
          ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hF,
          {$urandom, $urandom}, rnd_vec(), {$urandom, $urandom});
    end
    in_valid = 0;
    @(negedge clk);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule